// File: doc/BRIEF.md
# Banked Predicate Register File

This block stores the one-bit condition flags that guard instruction execution in a subword-parallel processor. It keeps 16 banks of 8 flags each, 128 in total. Only one bank is visible at a time. Software chooses that bank by loading a bank-select register. Instructions then name a flag with a 3-bit index into the visible bank. Flag 0 of every bank always reads as true, so an instruction guarded by index 0 always executes.

Two independent read ports return flags from the visible bank without delay. The compare unit writes its result through one or more write lanes. Each lane carries a relation bit, two destination indices and a mode bit. In normal mode the lane always writes a complementary pair: the relation goes to the first destination and its inverse to the second. In write-one mode the lane writes the pair only when the relation is true, and leaves both flags untouched when it is false. Because a write-one lane only ever writes the same polarity, several lanes can target the same flag in one cycle without conflict. All lanes, in both modes, are merged in one cycle.

Top module: `pred_bank_rf`

## Requirements
- R1: After reset every flag in every bank holds 0 and the bank-select register holds 0, so reads of indices 1 to 7 return 0.
- R2: When `bank_we` is high at a clock edge, `bank_sel` takes `bank_wdata` after that edge. Otherwise it keeps its value. Reads and writes act only on the bank that `bank_sel` names, and the other banks keep their contents.
- R3: A read of index 0 returns 1 on either read port, in every bank, whatever has been written.
- R4: A lane destination equal to index 0 is dropped. The lane's other destination is still written as usual.
- R5: A valid lane with `wr_pw1`=0 and relation 1 writes 1 to its first destination and 0 to its second. With relation 0 it writes 0 to the first and 1 to the second. The result is visible on the read ports in the cycle after the edge.
- R6: A valid lane with `wr_pw1`=1 and relation 1 writes 1 to its first destination and 0 to its second. With relation 0 it leaves both destinations unchanged.
- R7: All lanes with valid set are applied in the same cycle. Every flag that any lane writes to 1 becomes 1. Every flag that a lane writes to 0 and no lane writes to 1 becomes 0. A 1-write wins over a 0-write to the same flag, and this includes a lane whose two destinations are equal.
- R8: Reads are combinational from the stored state. In a cycle where a flag is also being written, the read returns the value from before the write.
- R9: Compare writes in the same cycle as a bank load go to the bank that was selected before the load.
- R10: The two read ports address flags independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_we | input | 1 | Load the bank-select register |
| bank_wdata | input | 4 | New bank number |
| bank_sel | output | 4 | Currently selected bank |
| wr_valid | input | 2 | Per-lane write valid |
| wr_pw1 | input | 2 | Per-lane mode: 1 = write-one mode, 0 = normal mode |
| wr_rel | input | 2 | Per-lane relation result |
| wr_dst1 | input | 6 | Per-lane first destination index; lane k uses bits [3k+2:3k] |
| wr_dst2 | input | 6 | Per-lane second destination index; same packing as `wr_dst1` |
| rd_idx_a | input | 3 | Read port A index |
| rd_val_a | output | 1 | Read port A flag value |
| rd_idx_b | input | 3 | Read port B index |
| rd_val_b | output | 1 | Read port B flag value |

## Verification
The assertions check the following on every cycle:
- index 0 reads as true on both ports;
- the bank register loads on `bank_we` and holds otherwise;
- a lone normal-mode lane leaves the complementary pair it wrote;
- the visible bank stays still when only false write-one lanes are active;
- each nonzero read equals the stored flag.

Some behaviours only the bench scenarios can show:
- how set and clear merge when several lanes hit the same flag;
- that same-cycle bank loads send writes to the old bank;
- that every other bank keeps its contents.

The bench shows these by comparing each read against an arithmetic model across bank sweeps and a long pseudo-random run.

// File: rtl/pred_bank_pkg.sv
package pred_bank_pkg;
  // Default geometry of the predicate file.
  localparam int unsigned BANKS_DEF   = 16;
  localparam int unsigned PER_BANK_DEF = 8;
  localparam int unsigned LANES_DEF   = 2;

  // Index of the flag that always reads as true.
  localparam int unsigned ALWAYS_TRUE_IDX = 0;
endpackage

// File: rtl/pred_wr_decode.sv
// Turns the compare write lanes into merged set / clear masks for one bank.
module pred_wr_decode #(
  parameter int unsigned PER_BANK = pred_bank_pkg::PER_BANK_DEF,
  parameter int unsigned LANES    = pred_bank_pkg::LANES_DEF,
  localparam int unsigned IDX_W   = $clog2(PER_BANK)
) (
  input  logic [LANES-1:0]       wr_valid,
  input  logic [LANES-1:0]       wr_pw1,
  input  logic [LANES-1:0]       wr_rel,
  input  logic [LANES*IDX_W-1:0] wr_dst1,
  input  logic [LANES*IDX_W-1:0] wr_dst2,
  output logic [PER_BANK-1:0]    set_mask,
  output logic [PER_BANK-1:0]    clr_mask
);
  logic [LANES-1:0][PER_BANK-1:0] lane_set;
  logic [LANES-1:0][PER_BANK-1:0] lane_clr;
  // Index 0 is never writable.
  localparam logic [PER_BANK-1:0] WR_ALLOWED = ~PER_BANK'(1);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic             fire;
    logic [IDX_W-1:0] one_idx;
    logic [IDX_W-1:0] zero_idx;
    always_comb begin
      fire     = wr_valid[l] && (!wr_pw1[l] || wr_rel[l]);
      one_idx  = wr_rel[l] ? wr_dst1[l*IDX_W +: IDX_W] : wr_dst2[l*IDX_W +: IDX_W];
      zero_idx = wr_rel[l] ? wr_dst2[l*IDX_W +: IDX_W] : wr_dst1[l*IDX_W +: IDX_W];
      lane_set[l] = fire ? ((PER_BANK'(1) << one_idx) & WR_ALLOWED)  : '0;
      lane_clr[l] = fire ? ((PER_BANK'(1) << zero_idx) & WR_ALLOWED) : '0;
    end
  end

  always_comb begin
    set_mask = '0;
    clr_mask = '0;
    for (int l = 0; l < LANES; l++) begin
      set_mask = set_mask | lane_set[l];
      clr_mask = clr_mask | lane_clr[l];
    end
  end
endmodule

// File: rtl/pred_store.sv
// Bank-select register plus the flag storage, one enabled row per bank.
module pred_store #(
  parameter int unsigned BANKS    = pred_bank_pkg::BANKS_DEF,
  parameter int unsigned PER_BANK = pred_bank_pkg::PER_BANK_DEF,
  localparam int unsigned BANK_W  = $clog2(BANKS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bank_we,
  input  logic [BANK_W-1:0]   bank_wdata,
  input  logic [PER_BANK-1:0] set_mask,
  input  logic [PER_BANK-1:0] clr_mask,
  output logic [BANK_W-1:0]   bank_sel,
  output logic [PER_BANK-1:0] act_row
);
  logic [BANK_W-1:0]              bank_q;
  logic [BANKS-1:0][PER_BANK-1:0] rows_q;
  logic [PER_BANK-1:0]            row_upd;
  logic                           any_wr;

  // Next-state for the visible row: 1-writes dominate 0-writes.
  always_comb begin
    act_row = rows_q[bank_q];
    row_upd = set_mask | (act_row & ~clr_mask);
    any_wr  = |(set_mask | clr_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bank_q <= '0;
    else if (bank_we) bank_q <= bank_wdata;
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_row
    logic row_en;
    always_comb row_en = any_wr && (bank_q == BANK_W'(b));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rows_q[b] <= '0;
      else if (row_en) rows_q[b] <= row_upd;
    end
  end

  assign bank_sel = bank_q;
endmodule

// File: rtl/pred_rd_port.sv
// One read port into the visible bank; index 0 is hard-wired true.
module pred_rd_port #(
  parameter int unsigned PER_BANK = pred_bank_pkg::PER_BANK_DEF,
  localparam int unsigned IDX_W   = $clog2(PER_BANK)
) (
  input  logic [PER_BANK-1:0] row,
  input  logic [IDX_W-1:0]    idx,
  output logic                val
);
  always_comb val = (idx == IDX_W'(pred_bank_pkg::ALWAYS_TRUE_IDX)) ? 1'b1 : row[idx];
endmodule

// File: rtl/pred_bank_rf.sv
module pred_bank_rf #(
  parameter int unsigned BANKS    = pred_bank_pkg::BANKS_DEF,
  parameter int unsigned PER_BANK = pred_bank_pkg::PER_BANK_DEF,
  parameter int unsigned LANES    = pred_bank_pkg::LANES_DEF,
  localparam int unsigned BANK_W  = $clog2(BANKS),
  localparam int unsigned IDX_W   = $clog2(PER_BANK)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bank_we,
  input  logic [BANK_W-1:0]      bank_wdata,
  output logic [BANK_W-1:0]      bank_sel,
  input  logic [LANES-1:0]       wr_valid,
  input  logic [LANES-1:0]       wr_pw1,
  input  logic [LANES-1:0]       wr_rel,
  input  logic [LANES*IDX_W-1:0] wr_dst1,
  input  logic [LANES*IDX_W-1:0] wr_dst2,
  input  logic [IDX_W-1:0]       rd_idx_a,
  output logic                   rd_val_a,
  input  logic [IDX_W-1:0]       rd_idx_b,
  output logic                   rd_val_b
);
  logic [PER_BANK-1:0] set_mask;
  logic [PER_BANK-1:0] clr_mask;
  logic [PER_BANK-1:0] act_row;

  pred_wr_decode #(.PER_BANK(PER_BANK), .LANES(LANES)) u_dec (
    .wr_valid(wr_valid), .wr_pw1(wr_pw1), .wr_rel(wr_rel),
    .wr_dst1(wr_dst1), .wr_dst2(wr_dst2),
    .set_mask(set_mask), .clr_mask(clr_mask)
  );

  pred_store #(.BANKS(BANKS), .PER_BANK(PER_BANK)) u_store (
    .clk(clk), .rst_n(rst_n), .bank_we(bank_we), .bank_wdata(bank_wdata),
    .set_mask(set_mask), .clr_mask(clr_mask),
    .bank_sel(bank_sel), .act_row(act_row)
  );

  pred_rd_port #(.PER_BANK(PER_BANK)) u_rd_a (.row(act_row), .idx(rd_idx_a), .val(rd_val_a));
  pred_rd_port #(.PER_BANK(PER_BANK)) u_rd_b (.row(act_row), .idx(rd_idx_b), .val(rd_val_b));
endmodule

// File: rtl/pred_bank_rf_chk.sv
module pred_bank_rf_chk #(
  parameter int unsigned BANKS    = 16,
  parameter int unsigned PER_BANK = 8,
  parameter int unsigned LANES    = 2,
  localparam int unsigned BANK_W  = $clog2(BANKS),
  localparam int unsigned IDX_W   = $clog2(PER_BANK)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bank_we,
  input logic [BANK_W-1:0]      bank_wdata,
  input logic [BANK_W-1:0]      bank_sel,
  input logic [LANES-1:0]       wr_valid,
  input logic [LANES-1:0]       wr_pw1,
  input logic [LANES-1:0]       wr_rel,
  input logic [LANES*IDX_W-1:0] wr_dst1,
  input logic [LANES*IDX_W-1:0] wr_dst2,
  input logic [IDX_W-1:0]       rd_idx_a,
  input logic                   rd_val_a,
  input logic [IDX_W-1:0]       rd_idx_b,
  input logic                   rd_val_b,
  input logic [PER_BANK-1:0]    act_row
);
  logic             quiet;
  logic             solo_norm;
  logic [IDX_W-1:0] d1_0;
  logic [IDX_W-1:0] d2_0;

  always_comb begin
    d1_0  = wr_dst1[IDX_W-1:0];
    d2_0  = wr_dst2[IDX_W-1:0];
    quiet = !bank_we && ((wr_valid & (~wr_pw1 | wr_rel)) == '0);
    solo_norm = !bank_we && (wr_valid == LANES'(1)) && !wr_pw1[0] &&
                (d1_0 != '0) && (d2_0 != '0) && (d1_0 != d2_0);
  end

  p_idx0_true_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx_a == '0) |-> rd_val_a);
  p_idx0_true_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx_b == '0) |-> rd_val_b);
  p_bank_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bank_we |=> (bank_sel == $past(bank_wdata)));
  p_bank_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_we |=> $stable(bank_sel));
  p_pw1_false_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |=> $stable(act_row));
  p_normal_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    solo_norm |=> ((act_row[$past(d1_0)] == $past(wr_rel[0])) &&
                   (act_row[$past(d2_0)] == !$past(wr_rel[0]))));
  p_read_is_stored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx_a != '0) |-> (rd_val_a == act_row[rd_idx_a]));
endmodule

bind pred_bank_rf pred_bank_rf_chk #(.BANKS(BANKS), .PER_BANK(PER_BANK), .LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .bank_we(bank_we), .bank_wdata(bank_wdata),
  .bank_sel(bank_sel), .wr_valid(wr_valid), .wr_pw1(wr_pw1), .wr_rel(wr_rel),
  .wr_dst1(wr_dst1), .wr_dst2(wr_dst2), .rd_idx_a(rd_idx_a), .rd_val_a(rd_val_a),
  .rd_idx_b(rd_idx_b), .rd_val_b(rd_val_b), .act_row(act_row)
);

// File: tb/pred_bank_rf_test.sv
module pred_bank_rf_test;
  localparam int NB = 16;
  localparam int PB = 8;
  localparam int NL = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bank_we;
  logic [3:0] bank_wdata;
  logic [3:0] bank_sel;
  logic [1:0] wr_valid, wr_pw1, wr_rel;
  logic [5:0] wr_dst1, wr_dst2;
  logic [2:0] rd_idx_a, rd_idx_b;
  logic       rd_val_a, rd_val_b;

  int checks = 0;
  int errors = 0;
  bit mdl [NB][PB];
  int mbank;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  pred_bank_rf #(.BANKS(NB), .PER_BANK(PB), .LANES(NL)) uut (
    .clk(clk), .rst_n(rst_n), .bank_we(bank_we), .bank_wdata(bank_wdata),
    .bank_sel(bank_sel), .wr_valid(wr_valid), .wr_pw1(wr_pw1), .wr_rel(wr_rel),
    .wr_dst1(wr_dst1), .wr_dst2(wr_dst2), .rd_idx_a(rd_idx_a), .rd_val_a(rd_val_a),
    .rd_idx_b(rd_idx_b), .rd_val_b(rd_val_b)
  );

  always #10 clk = ~clk;

  function automatic bit expv(input int idx);
    return (idx == 0) ? 1'b1 : mdl[mbank][idx];
  endfunction

  task automatic chk(input string tag, input string what, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0b expected %0b", tag, what, got, exp);
    end
  endtask

  // One cycle: drive at the falling edge, check pre-edge reads, then advance the model.
  task automatic step(input string tag, input bit bwe, input int bwd,
                      input bit [1:0] v, input bit [1:0] pw, input bit [1:0] rl,
                      input int a1, input int a2, input int b1, input int b2,
                      input int ra, input int rb);
    bit sm [PB];
    bit cm [PB];
    @(negedge clk);
    bank_we = bwe; bank_wdata = 4'(bwd);
    wr_valid = v; wr_pw1 = pw; wr_rel = rl;
    wr_dst1 = {3'(b1), 3'(a1)};
    wr_dst2 = {3'(b2), 3'(a2)};
    rd_idx_a = 3'(ra); rd_idx_b = 3'(rb);
    #1;
    chk(tag, $sformatf("port a idx %0d bank %0d", ra, mbank), rd_val_a, expv(ra));
    chk(tag, $sformatf("port b idx %0d bank %0d", rb, mbank), rd_val_b, expv(rb));
    for (int i = 0; i < PB; i++) begin sm[i] = 0; cm[i] = 0; end
    for (int l = 0; l < NL; l++) begin
      int d1, d2, one_t, zero_t;
      d1 = (l == 0) ? a1 : b1;
      d2 = (l == 0) ? a2 : b2;
      if (v[l] && (!pw[l] || rl[l])) begin
        one_t  = rl[l] ? d1 : d2;
        zero_t = rl[l] ? d2 : d1;
        if (one_t != 0)  sm[one_t] = 1;
        if (zero_t != 0) cm[zero_t] = 1;
      end
    end
    for (int i = 0; i < PB; i++) begin
      if (sm[i]) mdl[mbank][i] = 1;
      else if (cm[i]) mdl[mbank][i] = 0;
    end
    if (bwe) mbank = bwd;
  endtask

  task automatic idle_read(input string tag, input int ra, input int rb);
    step(tag, 0, 0, 2'b00, 2'b00, 2'b00, 0, 0, 0, 0, ra, rb);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    for (int b = 0; b < NB; b++) for (int i = 0; i < PB; i++) mdl[b][i] = 0;
    mbank = 0;
    rst_n = 1'b0; bank_we = 0; bank_wdata = 0; wr_valid = 0; wr_pw1 = 0; wr_rel = 0;
    wr_dst1 = 0; wr_dst2 = 0; rd_idx_a = 0; rd_idx_b = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1 chk("R1", "bank_sel after reset", bank_sel[0], 1'b0);
    checks++; if (bank_sel !== 4'd0) begin errors++; $display("FAIL R1 bank_sel: got %0d expected 0", bank_sel); end

    // R1 / R3 sweep: every bank, every index reads its reset value.
    for (int b = 0; b < NB; b++) begin
      step("R2", 1, b, 2'b00, 2'b00, 2'b00, 0, 0, 0, 0, 1, 2);
      for (int i = 0; i < PB; i++) idle_read((i == 0) ? "R3" : "R1", i, PB - 1 - i);
    end

    // R5: normal mode in bank 3.
    step("R2", 1, 3, 2'b00, 2'b00, 2'b00, 0, 0, 0, 0, 0, 0);
    step("R5", 0, 0, 2'b01, 2'b00, 2'b01, 2, 5, 0, 0, 2, 5);
    idle_read("R5", 2, 5);
    step("R5", 0, 0, 2'b01, 2'b00, 2'b00, 2, 5, 0, 0, 2, 5);
    idle_read("R5", 2, 5);

    // R6: write-one mode, false then true.
    step("R6", 0, 0, 2'b01, 2'b01, 2'b00, 2, 5, 0, 0, 2, 5);
    idle_read("R6", 2, 5);
    step("R6", 0, 0, 2'b01, 2'b01, 2'b01, 5, 2, 0, 0, 5, 2);
    idle_read("R6", 5, 2);

    // R7: two lanes on the same flag, and a set/clear clash.
    step("R7", 0, 0, 2'b11, 2'b11, 2'b11, 6, 7, 6, 7, 6, 7);
    idle_read("R7", 6, 7);
    step("R7", 0, 0, 2'b11, 2'b01, 2'b11, 4, 1, 1, 4, 4, 1);
    idle_read("R7", 4, 1);
    step("R7", 0, 0, 2'b01, 2'b00, 2'b01, 3, 3, 0, 0, 3, 3);
    idle_read("R7", 3, 3);

    // R4: destination 0 dropped, other destination still written.
    step("R4", 0, 0, 2'b01, 2'b00, 2'b01, 0, 6, 0, 0, 6, 0);
    idle_read("R4", 6, 0);
    step("R4", 0, 0, 2'b01, 2'b00, 2'b00, 0, 6, 0, 0, 6, 0);
    idle_read("R4", 6, 0);

    // R8: read of a flag being written returns the old value.
    step("R8", 0, 0, 2'b01, 2'b00, 2'b00, 6, 1, 0, 0, 6, 1);
    idle_read("R8", 6, 1);

    // R9: bank load together with a write; write lands in old bank 3.
    step("R9", 1, 9, 2'b01, 2'b00, 2'b01, 7, 2, 0, 0, 7, 2);
    for (int i = 1; i < PB; i++) idle_read("R9", i, i);
    step("R9", 1, 3, 2'b00, 2'b00, 2'b00, 0, 0, 0, 0, 7, 2);
    for (int i = 1; i < PB; i++) idle_read("R9", i, PB - i);

    // R10 and R2: pseudo-random mix over all banks, both ports independent.
    for (int n = 0; n < 4000; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step("R10", (lfsr[31:28] == 4'h0), int'(lfsr[27:24]),
           lfsr[23:22], lfsr[21:20], lfsr[19:18],
           int'(lfsr[17:15]), int'(lfsr[14:12]), int'(lfsr[11:9]), int'(lfsr[8:6]),
           int'(lfsr[5:3]), int'(lfsr[2:0]));
    end

    // Final sweep: every bank's contents match the model.
    for (int b = 0; b < NB; b++) begin
      step("R2", 1, b, 2'b00, 2'b00, 2'b00, 0, 0, 0, 0, 0, 0);
      for (int i = 0; i < PB; i += 2) idle_read("R2", i, i + 1);
    end
    finish_run();
  end
endmodule